// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit register datapath and a word-wide data memory. It takes one memory access request at a time. A request gives a base register value, a signed 16-bit displacement, an access size (byte, halfword or word), a direction (load or store) and, for loads, whether the result is signed or unsigned. The block adds the sign-extended displacement to the base to form the effective address and drives the memory port with that address.

On a store, the block replicates the low bits of the source value across the byte lanes and raises only the write strobes of the bytes the access covers. On a load, the memory returns a registered word one cycle after the request. The block then picks the addressed byte or halfword out of that word, using the address and size it captured on the request cycle, and widens the value to 32 bits with either sign or zero fill. A halfword access on an odd address, or a word access whose address is not a multiple of four, is flagged as misaligned and never reaches memory.

Requests enter on a valid/ready handshake, and every accepted request produces exactly one response on a second valid/ready handshake. `req_ready` is high only when no request is in flight and the response register is empty or being drained in that same cycle. So the consumer applies back-pressure by holding `rsp_ready` low. While `rsp_valid` is high and `rsp_ready` is low, the response stays frozen and no new request is taken.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `req_base` plus `req_disp` sign-extended to 32 bits, in the cycle the request is accepted (this includes negative displacements).
- R2: With `req_base` zero, `mem_addr` equals the sign-extended displacement. With `req_disp` zero, `mem_addr` equals `req_base`.
- R3: Size encoding is 0 = byte, 1 = halfword, 2 = word. Byte lane k holds bits [8k+7:8k], and address bits [1:0] give the lane (little-endian). An aligned store raises `mem_we` as follows: a word store gives 1111; a halfword store gives 0011 when address bit 1 is 0 and 1100 when it is 1; a byte store gives only bit [addr[1:0]]. A load raises no strobe.
- R4: An aligned store drives `mem_wdata` with the low byte copied to all four lanes (byte), the low halfword copied to both halves (halfword), or the whole source value (word). Only the bytes under the strobes reach memory.
- R5: A halfword access with address bit 0 set, or a word access with either of address bits [1:0] set, holds `mem_en` low and `mem_we` at 0000. Its response has `rsp_misalign` = 1 and `rsp_data` = 0, and the memory word it named is left unchanged.
- R6: A signed byte or halfword load (`req_unsigned` = 0) returns the addressed byte or halfword with its top bit copied into all upper bits of `rsp_data`.
- R7: An unsigned byte or halfword load (`req_unsigned` = 1) returns the addressed byte or halfword with the upper bits of `rsp_data` zero.
- R8: For a load, the block extends `mem_rdata` as sampled one cycle after the request. A word load returns that word unchanged.
- R9: `req_ready` is low while a request is in flight. A response held with `rsp_ready` low keeps `rsp_valid`, `rsp_data` and `rsp_misalign` stable until it is taken.
- R10: Each accepted request yields exactly one response, in request order. A store response carries `rsp_data` = 0.
- R11: After reset, `rsp_valid` and `mem_en` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word (3 behaves as word) |
| req_unsigned | input | 1 | Load extension: 1 zero-fill, 0 sign-fill |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_en | output | 1 | Memory access strobe |
| mem_addr | output | 32 | Effective byte address |
| mem_we | output | 4 | Per-byte write strobes |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Registered read word, valid the cycle after mem_en |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high together with rsp_valid |
| rsp_data | output | 32 | Extended load result, 0 for stores and misaligned accesses |
| rsp_misalign | output | 1 | Access was misaligned and did not reach memory |

## Verification
The bench uses the default parameters: 32-bit addresses and a 16-bit displacement. With these, the displacement sign bit is in play at both ends, 0x7FFF and 0x8000, and the bench forms effective addresses by adding to bases on either side of zero. A 16-word memory model is indexed by address bits [5:2]. This lets every byte lane, both halfword positions and every misaligned offset be stored and then read back. A consumer pattern that drops `rsp_ready` on a fixed cadence produces both held responses and same-cycle drains.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic              is_load;
    logic [1:0]        size;
    logic              zext;
    logic [LANE_W-1:0] lane;
    logic              misal;
  } pend_t;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misal_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;

  assign disp_sx = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign ea_o    = base_i + disp_sx;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misal_o = 1'b0;
      SZ_HALF: misal_o = ea_o[0];
      default: misal_o = |ea_o[LANE_W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  logic              en_i,
  input  logic [1:0]        size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [LANES-1:0]  strb_o,
  output logic [WORD_W-1:0] data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] LN = LANE_W'(g);
    logic hit;

    always_comb begin
      unique case (size_i)
        SZ_BYTE: hit = (lane_i == LN);
        SZ_HALF: hit = (lane_i[LANE_W-1] == LN[LANE_W-1]);
        default: hit = 1'b1;
      endcase
    end

    assign strb_o[g] = en_i & hit;

    always_comb begin
      unique case (size_i)
        SZ_BYTE: data_o[8*g +: 8] = wdata_i[7:0];
        SZ_HALF: data_o[8*g +: 8] = LN[0] ? wdata_i[15:8] : wdata_i[7:0];
        default: data_o[8*g +: 8] = wdata_i[8*g +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
  import lsu_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              zext_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] data_o
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  logic        fill_b;
  logic        fill_h;

  always_comb begin
    sel_b = rdata_i[7:0];
    for (int k = 0; k < LANES; k++) begin
      if (lane_i == LANE_W'(k)) sel_b = rdata_i[8*k +: 8];
    end
  end

  assign sel_h  = lane_i[LANE_W-1] ? rdata_i[31:16] : rdata_i[15:0];
  assign fill_b = ~zext_i & sel_b[7];
  assign fill_h = ~zext_i & sel_h[15];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(WORD_W-8){fill_b}}, sel_b};
      SZ_HALF: data_o = {{(WORD_W-16){fill_h}}, sel_h};
      default: data_o = rdata_i;
    endcase
  end

  // R7
  always_comb begin
    if (zext_i && size_i == SZ_BYTE)
      zext_byte_chk: assert (data_o[WORD_W-1:8] == '0);
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [31:0]       req_wdata,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_we,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_misalign
);
  logic [ADDR_W-1:0] ea;
  logic              misal;
  logic              accept;
  logic              st_en;
  logic              p_vld;
  pend_t             p_q;
  logic [31:0]       ext_data;
  logic              r_vld;
  logic [31:0]       r_data;
  logic              r_mis;

  lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .base_i (req_base),
    .disp_i (req_disp),
    .size_i (req_size),
    .ea_o   (ea),
    .misal_o(misal)
  );

  assign req_ready = ~p_vld & (~r_vld | rsp_ready);
  assign accept    = req_valid & req_ready;
  assign st_en     = accept & req_store & ~misal;

  lsu_store_lane u_store (
    .en_i   (st_en),
    .size_i (req_size),
    .lane_i (ea[LANE_W-1:0]),
    .wdata_i(req_wdata),
    .strb_o (mem_we),
    .data_o (mem_wdata)
  );

  assign mem_en   = accept & ~misal;
  assign mem_addr = ea;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld <= 1'b0;
      p_q   <= '0;
    end else begin
      p_vld <= accept;
      if (accept) begin
        p_q.is_load <= ~req_store;
        p_q.size    <= req_size;
        p_q.zext    <= req_unsigned;
        p_q.lane    <= ea[LANE_W-1:0];
        p_q.misal   <= misal;
      end
    end
  end

  lsu_load_extend u_ext (
    .size_i (p_q.size),
    .lane_i (p_q.lane),
    .zext_i (p_q.zext),
    .rdata_i(mem_rdata),
    .data_o (ext_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_vld  <= 1'b0;
      r_data <= '0;
      r_mis  <= 1'b0;
    end else if (p_vld) begin
      r_vld  <= 1'b1;
      r_data <= (p_q.is_load && !p_q.misal) ? ext_data : '0;
      r_mis  <= p_q.misal;
    end else if (rsp_ready) begin
      r_vld  <= 1'b0;
    end
  end

  assign rsp_valid    = r_vld;
  assign rsp_data     = r_data;
  assign rsp_misalign = r_mis;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_misalign)));

  // R9
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_vld |-> !req_ready);

  // R10
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_vld |-> (!rsp_valid || rsp_ready));

  // R5
  misal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == 2'd2 && (|mem_addr[1:0])) |-> (!mem_en && mem_we == 4'b0000));

  // R3
  strobe_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && req_store) |->
      ($countones(mem_we) == ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4)));
endmodule

// File: tb/test_lsu_lane_align.sv
module test_lsu_lane_align;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wdata;
  logic [15:0] req_disp;
  logic        mem_en;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_we;
  logic        rsp_valid, rsp_ready, rsp_misalign;
  logic [31:0] rsp_data;

  always #10 clk = ~clk;

  lsu_lane_align i_lsu_lane_align (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_disp(req_disp), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_misalign(rsp_misalign)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] mem_model [16];
  logic [31:0] shadow    [16];
  logic [31:0] exp_d [$];
  logic        exp_m [$];
  string       exp_t [$];

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model: registered read, byte-strobed write
  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mem_model[mem_addr[5:2]];
      for (int b = 0; b < 4; b++)
        if (mem_we[b]) mem_model[mem_addr[5:2]][8*b +: 8] = mem_wdata[8*b +: 8];
    end
  end

  // consumer with periodic back-pressure
  int rr_cnt = 0;
  always @(posedge clk) begin
    rr_cnt    <= rr_cnt + 1;
    rsp_ready <= rst_n && (rr_cnt % 5 != 2) && (rr_cnt % 7 != 3);
  end

  // monitor / scoreboard
  bit          held = 1'b0;
  logic [31:0] h_d;
  logic        h_m;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        chk(rsp_valid && rsp_data == h_d && rsp_misalign == h_m, "R9", "held response",
            rsp_data, h_d);
      end
      held = rsp_valid && !rsp_ready;
      h_d  = rsp_data;
      h_m  = rsp_misalign;
      if (rsp_valid && rsp_ready) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R10", "response with nothing pending", rsp_data, 32'h0);
        end else begin
          logic [31:0] d;
          logic        m;
          string       t;
          d = exp_d.pop_front();
          m = exp_m.pop_front();
          t = exp_t.pop_front();
          chk(rsp_data == d, t, "rsp_data", rsp_data, d);
          chk(rsp_misalign == m, t, "rsp_misalign", {31'b0, rsp_misalign}, {31'b0, m});
        end
      end
    end
  end

  task automatic issue(bit st, logic [1:0] sz, bit uns, logic [31:0] base,
                       logic [15:0] disp, logic [31:0] wd);
    logic [31:0] ea, repl, w, ed;
    logic [3:0]  stb;
    logic [7:0]  by;
    logic [15:0] hw;
    bit          mis;
    string       at;
    @(negedge clk);
    req_store = st; req_size = sz; req_unsigned = uns;
    req_base = base; req_disp = disp; req_wdata = wd; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    ea  = base + {{16{disp[15]}}, disp};
    mis = (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'b00);
    at  = (base == 0 || disp == 0) ? "R2" : "R1";
    case (sz)
      2'd0:    begin stb = 4'b0001 << ea[1:0];            repl = {4{wd[7:0]}};  end
      2'd1:    begin stb = ea[1] ? 4'b1100 : 4'b0011;     repl = {2{wd[15:0]}}; end
      default: begin stb = 4'b1111;                       repl = wd;            end
    endcase
    chk(mem_en == !mis, "R5", "mem_en", {31'b0, mem_en}, {31'b0, !mis});
    if (!mis) chk(mem_addr == ea, at, "mem_addr", mem_addr, ea);
    if (st && !mis) begin
      chk(mem_we == stb, "R3", "mem_we", {28'b0, mem_we}, {28'b0, stb});
      chk(mem_wdata == repl, "R4", "mem_wdata", mem_wdata, repl);
      for (int b = 0; b < 4; b++)
        if (stb[b]) shadow[ea[5:2]][8*b +: 8] = repl[8*b +: 8];
    end else begin
      chk(mem_we == 4'b0000, mis ? "R5" : "R3", "mem_we idle", {28'b0, mem_we}, 32'h0);
    end
    if (mis) begin
      exp_d.push_back(32'h0); exp_m.push_back(1'b1); exp_t.push_back("R5");
    end else if (st) begin
      exp_d.push_back(32'h0); exp_m.push_back(1'b0); exp_t.push_back("R10");
    end else begin
      w  = shadow[ea[5:2]];
      by = w[8*ea[1:0] +: 8];
      hw = ea[1] ? w[31:16] : w[15:0];
      case (sz)
        2'd0:    ed = uns ? {24'b0, by} : {{24{by[7]}}, by};
        2'd1:    ed = uns ? {16'b0, hw} : {{16{hw[15]}}, hw};
        default: ed = w;
      endcase
      exp_d.push_back(ed); exp_m.push_back(1'b0);
      exp_t.push_back(sz == 2'd2 ? "R8" : (uns ? "R7" : "R6"));
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk(!req_ready, "R9", "req_ready while in flight", {31'b0, req_ready}, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d pending", exp_d.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_model[i] = 32'h8844_2211 + i * 32'h1357_9BDF;
      shadow[i]    = mem_model[i];
    end
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
    req_unsigned = 1'b0; req_base = '0; req_disp = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11
    chk(!rsp_valid, "R11", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    chk(!mem_en, "R11", "mem_en after reset", {31'b0, mem_en}, 32'h0);
    chk(req_ready, "R11", "req_ready after reset", {31'b0, req_ready}, 32'h1);

    // R1 / R2 / R8: word loads with assorted address formation
    issue(0, 2'd2, 0, 32'h0000_1000, 16'hFFFC, 0);
    issue(0, 2'd2, 0, 32'h0000_0000, 16'h0008, 0);
    issue(0, 2'd2, 0, 32'h0000_002C, 16'h0000, 0);
    issue(0, 2'd2, 0, 32'hFFFF_8010, 16'h7FF4, 0);
    issue(0, 2'd2, 0, 32'h0001_8034, 16'h8000, 0);
    // R6 / R7: every byte lane, both halfword positions
    for (int l = 0; l < 4; l++) begin
      issue(0, 2'd0, 0, 32'h0000_0010, 16'(l), 0);
      issue(0, 2'd0, 1, 32'h0000_0010, 16'(l), 0);
    end
    for (int h = 0; h < 2; h++) begin
      issue(0, 2'd1, 0, 32'h0000_0020, 16'(2*h), 0);
      issue(0, 2'd1, 1, 32'h0000_0020, 16'(2*h), 0);
    end
    // R3 / R4: stores of each size and position, then read back
    for (int l = 0; l < 4; l++)
      issue(1, 2'd0, 0, 32'h0000_0030, 16'(l), 32'h1234_5680 + l);
    issue(0, 2'd2, 0, 32'h0000_0030, 16'h0000, 0);
    issue(1, 2'd1, 0, 32'h0000_0004, 16'h0000, 32'hDEAD_F00D);
    issue(1, 2'd1, 0, 32'h0000_0004, 16'h0002, 32'h0BAD_8123);
    issue(0, 2'd2, 0, 32'h0000_0004, 16'h0000, 0);
    issue(0, 2'd1, 0, 32'h0000_0004, 16'h0002, 0);
    issue(1, 2'd2, 0, 32'h0000_003C, 16'h0000, 32'hC001_D00D);
    issue(0, 2'd0, 0, 32'h0000_003C, 16'h0003, 0);
    issue(0, 2'd2, 0, 32'h0000_003C, 16'h0000, 0);
    // R5: misaligned accesses do nothing
    issue(1, 2'd1, 0, 32'h0000_0018, 16'h0001, 32'hFFFF_FFFF);
    issue(1, 2'd2, 0, 32'h0000_0018, 16'h0002, 32'hFFFF_FFFF);
    issue(1, 2'd2, 0, 32'h0000_0018, 16'h0003, 32'hFFFF_FFFF);
    issue(0, 2'd1, 0, 32'h0000_0018, 16'h0003, 0);
    issue(0, 2'd2, 1, 32'h0000_0019, 16'h0000, 0);
    issue(0, 2'd2, 0, 32'h0000_0018, 16'h0000, 0);

    for (int t = 0; t < 100 && exp_d.size() != 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_d.size() == 0, "R10", "responses outstanding", exp_d.size(), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule